// File: doc/BRIEF.md
# Successive-Approximation Band Search Controller

This controller picks the discrete tuning band of an oscillator by binary search. Outside the block, a frequency race between the reference clock and the divided oscillator clock is repeated, and each race yields one bit: which clock was faster. The controller holds the current band code and, after each race, moves the code toward the band whose frequency matches the reference. Every move is half the size of the one before.

After reset the band code sits at mid-scale and the controller reports busy. Each race-done strobe applies one move: up when the reference clock won, down when the feedback clock won. The weights fall from 64 to 1. After the seventh move the controller drops busy, raises done and holds the code until the next reset. All logic runs on the reference clock. The race result must already be synchronous to that clock when it arrives.

Top module: `band_search_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, band is 128 (mid-scale), busy is 1 and done is 0.
- R2: A race_done strobe while busy with ref_won=1 increases band by the current weight at that clock edge.
- R3: A race_done strobe while busy with ref_won=0 decreases band by the current weight at that clock edge.
- R4: Successive accepted strobes use the weights 64, 32, 16, 8, 4, 2, 1, in that order.
- R5: On cycles without a race_done strobe, band and the flags do not change.
- R6: The edge that applies the seventh move also clears busy and sets done. busy and done are always complementary.
- R7: Once done is set, further race_done strobes are ignored and band stays frozen until reset.
- R8: Asserting reset in the middle of a search, or more than once, restarts the search from mid-scale with weight 64.
- R9: In a closed loop with a monotonic band-to-frequency response, the final band is within 1 of the band where the response crosses the reference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset; restarts the search |
| race_done | input | 1 | One-cycle strobe: a frequency race has finished |
| ref_won | input | 1 | 1 if the reference clock won the race, 0 if the feedback clock won |
| band | output | 8 | Current band code |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search finished, band frozen |

## Verification
The step weight is internal state, so an error in it stays hidden until the next accepted strobe. At that edge the band moves by the wrong amount, or done changes on the wrong strobe. A per-cycle reference model catches this on the same cycle as the faulty move. A band that drifts without a strobe shows up at the very next edge. Closed-loop runs against several target crossings show whether small early errors build up to a final band more than one code from the target.

// File: rtl/band_search_ctrl.sv
module band_search_ctrl #(
  parameter int BAND_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              race_done,
  input  logic              ref_won,
  output logic [BAND_W-1:0] band,
  output logic              busy,
  output logic              done
);
  localparam logic [BAND_W-1:0] MID   = BAND_W'(1) << (BAND_W - 1);
  localparam logic [BAND_W-1:0] FIRST = BAND_W'(1) << (BAND_W - 2);

  logic [BAND_W-1:0] weight;
  logic              take;

  assign busy = |weight;
  assign done = ~busy;
  assign take = race_done & busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      band   <= MID;
      weight <= FIRST;
    end else if (take) begin
      band   <= ref_won ? band + weight : band - weight;
      weight <= weight >> 1;
    end
  end

  AST_START_MID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (band == MID && busy)); // R1
  AST_UP_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (race_done && busy && ref_won) |=> (band > $past(band))); // R2
  AST_DOWN_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (race_done && busy && !ref_won) |=> (band < $past(band))); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !race_done |=> ($stable(band) && $stable(busy))); // R5
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ($stable(band) && done)); // R7
endmodule

// File: tb/tb_band_search_ctrl.sv
module tb_band_search_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       race_done = 1'b0;
  logic       ref_won = 1'b0;
  logic [7:0] band;
  logic       busy, done;

  int compared = 0;
  int mismatched = 0;
  int m_band, m_w, m_left;

  always #4 clk = ~clk;

  band_search_ctrl #(.BAND_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .race_done(race_done), .ref_won(ref_won),
    .band(band), .busy(busy), .done(done)
  );

  task automatic check(input string tag, input int act, input int exp, input string what);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic rn, input logic strobe, input logic won, input string tag);
    @(negedge clk);
    rst_n = rn; race_done = strobe; ref_won = won;
    @(posedge clk);
    #1;
    if (!rn) begin
      m_band = 128; m_w = 64; m_left = 7;
    end else if (strobe && m_left > 0) begin
      m_band = won ? m_band + m_w : m_band - m_w;
      m_w = m_w / 2;
      m_left--;
    end
    check(tag, int'(band), m_band, "band");
    check(tag, int'(busy), (m_left > 0) ? 1 : 0, "busy");
    check(tag, int'(done), (m_left == 0) ? 1 : 0, "done");
  endtask

  task automatic closed_loop(input int target);
    step(1'b0, 1'b0, 1'b0, "R8");
    step(1'b1, 1'b0, 1'b0, "R1");
    for (int k = 0; k < 20 && busy; k++) begin
      step(1'b1, 1'b0, 1'b0, "R5");
      step(1'b1, 1'b1, (int'(band) < target), "R4");
    end
    compared++;
    if (!done || int'(band) > target + 1 || int'(band) < target - 1) begin
      mismatched++;
      $display("FAIL R9 target %0d: actual band %0d done %0d expected within 1", target, band, done);
    end
  endtask

  initial begin
    #1000000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    step(1'b0, 1'b0, 1'b0, "R1");
    step(1'b0, 1'b1, 1'b1, "R1");
    step(1'b1, 1'b0, 1'b0, "R1");
    step(1'b1, 1'b0, 1'b1, "R5");
    // R2, R3, R4: mixed pattern
    step(1'b1, 1'b1, 1'b1, "R2");
    step(1'b1, 1'b1, 1'b0, "R3");
    step(1'b1, 1'b0, 1'b1, "R5");
    step(1'b1, 1'b1, 1'b1, "R4");
    step(1'b1, 1'b1, 1'b1, "R4");
    step(1'b1, 1'b1, 1'b0, "R4");
    step(1'b1, 1'b1, 1'b0, "R4");
    step(1'b1, 1'b1, 1'b1, "R6");
    // R7: strobes after done are ignored
    step(1'b1, 1'b1, 1'b1, "R7");
    step(1'b1, 1'b1, 1'b0, "R7");
    // R8: reset mid-search, repeated
    step(1'b0, 1'b0, 1'b0, "R8");
    step(1'b1, 1'b1, 1'b0, "R8");
    step(1'b1, 1'b1, 1'b0, "R8");
    step(1'b0, 1'b0, 1'b0, "R8");
    step(1'b0, 1'b0, 1'b0, "R8");
    step(1'b1, 1'b1, 1'b1, "R8");
    // all-up and all-down extremes
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b1, "R2");
    step(1'b1, 1'b1, 1'b1, "R7");
    step(1'b0, 1'b0, 1'b0, "R8");
    for (int i = 0; i < 7; i++) step(1'b1, 1'b1, 1'b0, "R3");
    step(1'b1, 1'b1, 1'b1, "R7");
    // R9: closed loop with monotonic response freq(b) = b
    closed_loop(1);
    closed_loop(37);
    closed_loop(128);
    closed_loop(129);
    closed_loop(200);
    closed_loop(255);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule